// File: doc/BRIEF.md
# Serial Elastic Store with Programmable Byte Latency

This block sits between a receive framer and the terminal side of an E1-rate link. Payload bits arrive one per cycle of the recovered line clock and are written into a circular bit store. A separate 2.048 MHz serial clock, supplied by the terminal equipment, shifts them back out. The delay between the two is programmed in whole bytes, from one byte up to a full 256-bit frame. The two clocks must be phase-locked outside the block. When they drift apart, the store runs too full or runs dry. Each condition is latched as a sticky flag, and the read side jumps back to the programmed distance behind the writer.

The write pointer crosses into the read domain as Gray code. The read side stays idle and drives ones until the fill level it sees reaches the programmed latency. Once primed, it keeps a 256-bit frame position counter. It either announces bit 0 of each frame on a sync output, or it takes frame alignment from an external sync input, as selected by a direction bit. A two-bit mode field enables the block. Every encoding except binary 10 holds it idle.

Top module: `rx_elastic_fifo`

## Requirements
- R1: The block runs only when `mode` is binary 10. With any other mode value, `rdata` stays 1, `sync_o` stays 0, the write pointer does not advance, and neither flag is set.
- R2: Once primed, `rdata` reproduces the written bits in order. The clocks run at equal rate, and read edge m is the first read edge after write edge m. Counting write edges from the first enabled one, the bit written at write edge m appears on `rdata` after read edge m + 8L + 1, where L is the latency in bytes.
- R3: The 5-bit latency field gives L directly for values 1 to 31. The value 0 selects L = 32, which is 256 bits.
- R4: The latency register resets to 4 bytes. It loads `cfg_lat` on a read-clock edge where `cfg_lat_we` is 1 and read reset is low.
- R5: While the read side is not primed, including directly after reset, `rdata` is 1.
- R6: When `sync_dir` is 0, `sync_oe` is 1 and `sync_o` is high for exactly one read clock together with the first primed bit. The pulse repeats every 256 read clocks after that.
- R7: When `sync_dir` is 1, `sync_oe` and `sync_o` are 0. While primed, a read edge that samples `sync_i` high makes the bit launched at that edge frame position 0. Pulses seen after switching back to output direction follow that alignment.
- R8: A fill level above 256 bits, as seen by the read side, sets `ovr_flag`. It also restarts reading at L·8 bits behind the writer, so the R2 relation holds again afterwards.
- R9: A fill level of zero while primed sets `udr_flag` and restarts reading in the same way.
- R10: Both flags are 0 after read reset. Once set, each stays set until the next read reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Recovered line clock (write side) |
| wrst | input | 1 | Synchronous active-high reset, write domain |
| wdata | input | 1 | Serial payload bit in |
| rclk | input | 1 | External serial read clock |
| rrst | input | 1 | Synchronous active-high reset, read domain |
| mode | input | 2 | Buffer mode; 2'b10 enables the block |
| cfg_lat_we | input | 1 | Load strobe for the latency register (read domain) |
| cfg_lat | input | 5 | Latency in bytes; 0 means 32 |
| sync_dir | input | 1 | 0: sync is driven out, 1: sync is taken in |
| sync_i | input | 1 | External frame sync, sampled on rclk |
| rdata | output | 1 | Serial payload bit out |
| sync_o | output | 1 | Frame sync pulse out |
| sync_oe | output | 1 | Output enable for the sync pin |
| ovr_flag | output | 1 | Sticky overrun flag |
| udr_flag | output | 1 | Sticky underrun flag |

## Verification
The bench uses the package defaults: a 256-bit frame, a 512-bit store, 10-bit pointers and a two-stage synchronizer. With these values the full one-frame latency (field value 0) fits in a run of a few hundred cycles. The frame counter wraps inside each run, so repeated sync pulses can be checked. Stopping one clock for about 300 cycles drives the fill level past 256 or down to zero, which exercises overrun and underrun along with the recentering that follows.

// File: rtl/rxef_pkg.sv
package rxef_pkg;

    localparam int FRAME_BITS = 256;
    localparam int BYTE_BITS  = 8;
    localparam int LAT_W      = 5;
    localparam int SYNC_STAGES = 2;

    localparam int BUF_BITS = 2 * FRAME_BITS;
    localparam int ADDR_W   = $clog2(BUF_BITS);
    localparam int PTR_W    = ADDR_W + 1;
    localparam int POS_W    = $clog2(FRAME_BITS);
    localparam int BYTE_SH  = $clog2(BYTE_BITS);

    localparam logic [1:0]       MODE_FIFO = 2'b10;
    localparam logic [LAT_W-1:0] LAT_RESET = LAT_W'(4);

    typedef logic [PTR_W-1:0] ptr_t;
    localparam ptr_t FRAME_PTR = ptr_t'(FRAME_BITS);

    typedef enum logic {
        ST_FILL = 1'b0,
        ST_RUN  = 1'b1
    } rd_state_e;

    typedef struct packed {
        rd_state_e        st;
        ptr_t             rptr;
        logic [POS_W-1:0] pos;
        logic [LAT_W-1:0] lat;
        logic             rbit;
        logic             ovr;
        logic             udr;
    } rd_regs_t;

    localparam rd_regs_t RD_RESET = '{
        st:   ST_FILL,
        rptr: '0,
        pos:  '0,
        lat:  LAT_RESET,
        rbit: 1'b1,
        ovr:  1'b0,
        udr:  1'b0
    };

    function automatic ptr_t bin2gray(input ptr_t b);
        return b ^ (b >> 1);
    endfunction

    function automatic ptr_t gray2bin(input ptr_t g);
        ptr_t b;
        b[PTR_W-1] = g[PTR_W-1];
        for (int i = PTR_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    function automatic ptr_t lat_to_bits(input logic [LAT_W-1:0] l);
        if (l == '0) begin
            return FRAME_PTR;
        end
        return ptr_t'(l) << BYTE_SH;
    endfunction

endpackage

// File: rtl/rxef_bitstore.sv
module rxef_bitstore
    import rxef_pkg::*;
(
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic              wbit,
    input  logic [ADDR_W-1:0] raddr,
    output logic              rbit
);

    logic [BUF_BITS-1:0] cells;

    always_ff @(posedge wclk) begin
        if (we) begin
            cells[waddr] <= wbit;
        end
    end

    assign rbit = cells[raddr];

endmodule

// File: rtl/rxef_sync.sv
module rxef_sync
    import rxef_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  ptr_t d,
    output ptr_t q
);

    ptr_t stage [SYNC_STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SYNC_STAGES; s++) begin
                stage[s] <= '0;
            end
        end else begin
            stage[0] <= d;
            for (int s = 1; s < SYNC_STAGES; s++) begin
                stage[s] <= stage[s-1];
            end
        end
    end

    assign q = stage[SYNC_STAGES-1];

endmodule

// File: rtl/rxef_wr_side.sv
module rxef_wr_side
    import rxef_pkg::*;
(
    input  logic              wclk,
    input  logic              wrst,
    input  logic              en,
    output logic              we,
    output logic [ADDR_W-1:0] waddr,
    output ptr_t              wgray
);

    ptr_t wptr;
    ptr_t wptr_nx;

    assign wptr_nx = wptr + ptr_t'(1);

    always_ff @(posedge wclk) begin
        if (wrst) begin
            wptr  <= '0;
            wgray <= '0;
        end else if (en) begin
            wptr  <= wptr_nx;
            wgray <= bin2gray(wptr_nx);
        end
    end

    assign we    = en && !wrst;
    assign waddr = wptr[ADDR_W-1:0];

    // R2: the crossing pointer never moves more than one bit per write clock
    p_gray_step_r2: assert property (@(posedge wclk) disable iff (wrst)
        $countones(wgray ^ $past(wgray)) <= 1);

    // R1: the write pointer is frozen while the mode field is not FIFO
    p_hold_off_r1: assert property (@(posedge wclk) disable iff (wrst)
        !en |=> $stable(wptr));

endmodule

// File: rtl/rxef_rd_side.sv
module rxef_rd_side
    import rxef_pkg::*;
(
    input  logic              rclk,
    input  logic              rrst,
    input  logic              en,
    input  ptr_t              wgray_s,
    input  logic              cfg_we,
    input  logic [LAT_W-1:0]  cfg_lat,
    input  logic              sync_dir,
    input  logic              sync_i,
    input  logic              rbit,
    output logic [ADDR_W-1:0] raddr,
    output logic              rdata,
    output logic              sync_o,
    output logic              ovr,
    output logic              udr
);

    rd_regs_t r, rn;
    ptr_t     wbin, fill, target, anchor;
    logic     over, under, slip;

    always_comb begin
        wbin   = gray2bin(wgray_s);
        fill   = wbin - r.rptr;
        target = lat_to_bits(r.lat);
        anchor = wbin - target;
        over   = fill > FRAME_PTR;
        under  = (fill == '0);
        slip   = (r.st == ST_RUN) && (over || under);
        raddr  = (r.st == ST_RUN && !slip) ? r.rptr[ADDR_W-1:0] : anchor[ADDR_W-1:0];
    end

    always_comb begin
        rn = r;
        if (cfg_we) begin
            rn.lat = cfg_lat;
        end
        if (!en) begin
            rn.st   = ST_FILL;
            rn.rptr = wbin;
            rn.rbit = 1'b1;
        end else if (r.st == ST_FILL) begin
            rn.rbit = 1'b1;
            if (fill >= target) begin
                rn.st   = ST_RUN;
                rn.rbit = rbit;
                rn.rptr = anchor + ptr_t'(1);
                rn.pos  = '0;
            end
        end else begin
            rn.rbit = rbit;
            rn.pos  = (sync_dir && sync_i) ? '0 : r.pos + POS_W'(1);
            if (slip) begin
                rn.rptr = anchor + ptr_t'(1);
                rn.ovr  = r.ovr | over;
                rn.udr  = r.udr | under;
            end else begin
                rn.rptr = r.rptr + ptr_t'(1);
            end
        end
    end

    always_ff @(posedge rclk) begin
        if (rrst) begin
            r <= RD_RESET;
        end else begin
            r <= rn;
        end
    end

    assign rdata  = r.rbit;
    assign sync_o = (r.st == ST_RUN) && (r.pos == '0) && !sync_dir;
    assign ovr    = r.ovr;
    assign udr    = r.udr;

    // R5: no payload leaves before the fill level reaches the latency
    p_fill_ones_r5: assert property (@(posedge rclk) disable iff (rrst)
        (r.st == ST_FILL && fill < target) |=> rdata);

    // R1: a disabled mode keeps the serial output idle
    p_mode_off_r1: assert property (@(posedge rclk) disable iff (rrst)
        !en |=> (rdata && !sync_o));

    // R6: a frame pulse lasts one read clock
    p_sync_once_r6: assert property (@(posedge rclk) disable iff (rrst)
        sync_o |=> !sync_o);

    // R10: flags stay set until reset
    p_ovr_sticky_r10: assert property (@(posedge rclk) disable iff (rrst)
        ovr |=> ovr);
    p_udr_sticky_r10: assert property (@(posedge rclk) disable iff (rrst)
        udr |=> udr);

    // R8: after an overrun the read pointer is back within one frame
    p_ovr_recenter_r8: assert property (@(posedge rclk) disable iff (rrst)
        (r.st == ST_RUN && over) |=> (r.rptr == $past(anchor) + ptr_t'(1)));

endmodule

// File: rtl/rx_elastic_fifo.sv
module rx_elastic_fifo
    import rxef_pkg::*;
(
    input  logic             wclk,
    input  logic             wrst,
    input  logic             wdata,
    input  logic             rclk,
    input  logic             rrst,
    input  logic [1:0]       mode,
    input  logic             cfg_lat_we,
    input  logic [LAT_W-1:0] cfg_lat,
    input  logic             sync_dir,
    input  logic             sync_i,
    output logic             rdata,
    output logic             sync_o,
    output logic             sync_oe,
    output logic             ovr_flag,
    output logic             udr_flag
);

    logic              en;
    logic              we;
    logic [ADDR_W-1:0] waddr, raddr;
    logic              rbit;
    ptr_t              wgray, wgray_s;

    assign en      = (mode == MODE_FIFO);
    assign sync_oe = !sync_dir;

    rxef_wr_side u_wr (
        .wclk  (wclk),
        .wrst  (wrst),
        .en    (en),
        .we    (we),
        .waddr (waddr),
        .wgray (wgray)
    );

    rxef_bitstore u_store (
        .wclk  (wclk),
        .we    (we),
        .waddr (waddr),
        .wbit  (wdata),
        .raddr (raddr),
        .rbit  (rbit)
    );

    rxef_sync u_wsync (
        .clk (rclk),
        .rst (rrst),
        .d   (wgray),
        .q   (wgray_s)
    );

    rxef_rd_side u_rd (
        .rclk     (rclk),
        .rrst     (rrst),
        .en       (en),
        .wgray_s  (wgray_s),
        .cfg_we   (cfg_lat_we),
        .cfg_lat  (cfg_lat),
        .sync_dir (sync_dir),
        .sync_i   (sync_i),
        .rbit     (rbit),
        .raddr    (raddr),
        .rdata    (rdata),
        .sync_o   (sync_o),
        .ovr      (ovr_flag),
        .udr      (udr_flag)
    );

endmodule

// File: tb/rx_elastic_fifo_test.sv
module rx_elastic_fifo_test;
    import rxef_pkg::*;

    logic wclk = 1'b0, rclk = 1'b0, wrun = 1'b1, rrun = 1'b1;
    logic wrst = 1'b1, rrst = 1'b1, wdata = 1'b0;
    logic [1:0] mode = 2'b00;
    logic cfg_lat_we = 1'b0;
    logic [LAT_W-1:0] cfg_lat = '0;
    logic sync_dir = 1'b0, sync_i = 1'b0;
    logic rdata, sync_o, sync_oe, ovr_flag, udr_flag;

    int total = 0;
    int bad = 0;
    int jcur = 0;
    bit stream [0:4095];

    rx_elastic_fifo uut (
        .wclk(wclk), .wrst(wrst), .wdata(wdata),
        .rclk(rclk), .rrst(rrst), .mode(mode),
        .cfg_lat_we(cfg_lat_we), .cfg_lat(cfg_lat),
        .sync_dir(sync_dir), .sync_i(sync_i),
        .rdata(rdata), .sync_o(sync_o), .sync_oe(sync_oe),
        .ovr_flag(ovr_flag), .udr_flag(udr_flag)
    );

    // 250 MHz clocks; read rises 1 ns after write, each can be paused
    initial begin
        #2;
        forever begin
            if (wrun) wclk = 1'b1;
            #2 wclk = 1'b0;
            #2;
        end
    end
    initial begin
        #3;
        forever begin
            if (rrun) rclk = 1'b1;
            #2 rclk = 1'b0;
            #2;
        end
    end

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int lat_bits(input int f);
        return (f == 0) ? FRAME_BITS : f * BYTE_BITS;
    endfunction

    function automatic logic exp_data(input int j, input int t);
        if (j < t + 1) return 1'b1;
        return stream[(j - t - 1) % 4096];
    endfunction

    function automatic logic exp_sync(input int j, input int t);
        return (j >= t + 1) && (((j - t - 1) % FRAME_BITS) == 0);
    endfunction

    task automatic do_reset();
        @(negedge wclk);
        wrst = 1'b1; rrst = 1'b1; mode = 2'b00; sync_i = 1'b0;
        repeat (3) @(negedge wclk);
        wrst = 1'b0; rrst = 1'b0;
    endtask

    task automatic start_run(input bit wr_lat, input int f);
        do_reset();
        if (wr_lat) begin
            @(negedge wclk);
            cfg_lat = LAT_W'(f); cfg_lat_we = 1'b1;
            @(negedge wclk);
            cfg_lat_we = 1'b0;
        end
        foreach (stream[i]) stream[i] = 1'($urandom);
        @(negedge wclk);
        mode = MODE_FIFO; jcur = 0; wdata = stream[0];
    endtask

    task automatic step(input int t, input bit cd, input bit cs, input string req);
        @(negedge wclk);
        if (cd) chk(req, "rdata", rdata, exp_data(jcur, t));
        if (cs) chk(req, "sync_o", sync_o, exp_sync(jcur, t));
        jcur++;
        wdata = stream[jcur % 4096];
    endtask

    initial begin
        int t, f, q;
        void'($urandom(32'h5eed));

        // reset state: R5, R6, R10
        repeat (2) @(negedge wclk);
        chk("R5", "rdata in reset", rdata, 1'b1);
        chk("R6", "sync_o in reset", sync_o, 1'b0);
        chk("R6", "sync_oe dir0", sync_oe, 1'b1);
        chk("R10", "ovr in reset", ovr_flag, 1'b0);
        chk("R10", "udr in reset", udr_flag, 1'b0);

        // default latency of 4 bytes: R4, R2, R5, R6
        start_run(1'b0, 0);
        t = 32;
        for (int i = 0; i < t + 300; i++) step(t, 1'b1, 1'b1, "R4");

        // smallest and largest latency: R3, R2
        start_run(1'b1, 1);
        t = lat_bits(1);
        for (int i = 0; i < t + 300; i++) step(t, 1'b1, 1'b1, "R3");
        start_run(1'b1, 0);
        t = lat_bits(0);
        for (int i = 0; i < t + 300; i++) step(t, 1'b1, 1'b1, "R3");

        // random latencies: R2, R6
        for (int k = 0; k < 3; k++) begin
            f = 2 + int'($urandom % 30);
            start_run(1'b1, f);
            t = lat_bits(f);
            for (int i = 0; i < t + 300; i++) step(t, 1'b1, 1'b1, "R2");
        end

        // sync as input: R7
        sync_dir = 1'b1;
        start_run(1'b1, 3);
        t = lat_bits(3);
        q = t + 50;
        while (jcur < q + 600) begin
            if (jcur == q) sync_i = 1'b1;
            if (jcur == q + 1) sync_i = 1'b0;
            if (jcur == q + 100) sync_dir = 1'b0;
            @(negedge wclk);
            chk("R7", "rdata", rdata, exp_data(jcur, t));
            if (sync_dir) begin
                chk("R7", "sync_oe dir1", sync_oe, 1'b0);
                chk("R7", "sync_o dir1", sync_o, 1'b0);
            end else if (jcur > q) begin
                chk("R7", "realigned sync_o", sync_o, 1'b0 == 1'b0 && ((jcur - q) % FRAME_BITS) == 0);
            end
            jcur++;
            wdata = stream[jcur % 4096];
        end

        // overrun by pausing the read clock: R8
        start_run(1'b1, 4);
        t = lat_bits(4);
        for (int i = 0; i < 100; i++) step(t, 1'b1, 1'b0, "R8");
        chk("R8", "ovr before pause", ovr_flag, 1'b0);
        rrun = 1'b0;
        for (int i = 0; i < 300; i++) step(t, 1'b0, 1'b0, "R8");
        rrun = 1'b1;
        for (int i = 0; i < 20; i++) step(t, 1'b0, 1'b0, "R8");
        chk("R8", "ovr set", ovr_flag, 1'b1);
        chk("R9", "udr clear on overrun", udr_flag, 1'b0);
        for (int i = 0; i < 100; i++) step(t, 1'b1, 1'b0, "R8");

        // underrun by pausing the write clock: R9, R10
        wrun = 1'b0;
        repeat (60) @(negedge rclk);
        chk("R9", "udr set", udr_flag, 1'b1);
        wrun = 1'b1;
        repeat (40) @(negedge rclk);
        chk("R10", "ovr sticky", ovr_flag, 1'b1);
        chk("R10", "udr sticky", udr_flag, 1'b1);
        do_reset();
        @(negedge wclk);
        chk("R10", "ovr cleared", ovr_flag, 1'b0);
        chk("R10", "udr cleared", udr_flag, 1'b0);

        // non-FIFO mode codes: R1
        for (int c = 0; c < 4; c++) begin
            if (c == 2) continue;
            mode = 2'(c);
            for (int i = 0; i < 150; i++) begin
                @(negedge wclk);
                wdata = 1'($urandom);
                chk("R1", "rdata idle", rdata, 1'b1);
                chk("R1", "sync_o idle", sync_o, 1'b0);
            end
        end
        chk("R1", "ovr idle", ovr_flag, 1'b0);
        chk("R1", "udr idle", udr_flag, 1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog expired at %0t", $time);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule